// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable ratio of 16×N + A, the feedback path of a frequency synthesizer. A dual-modulus prescaler counts either 17 or 16 input clocks per prescaler cycle. A swallow counter, loaded with A, holds the prescaler at ÷17 for the first A prescaler cycles of each output period. A programmable counter, loaded with N, ends the period after N prescaler cycles in total. The result is A×17 + (N−A)×16 input clocks per output period.

N and A are captured from the input buses by a load strobe into staging registers. The counters take the staged values only at a period boundary, or while the divider is held in standby, so a new setting never cuts a period short. A run input (power-save control) starts the divider when high. When it is low, the divider is held at the start of a fresh period and the output is quiet. A parameter selects the output form. It is either a one-clock pulse per period, for a phase comparator, or a square wave that toggles at every boundary, for a monitor pin.

Top module: `pswallow_div`

## Requirements
- R1: While run is high, the pulse output is high for one clock at every 16×N + A input clocks. The first pulse is seen after the T-th rising edge that samples run high, where T = 16×N + A.
- R2: No pulse occurs between period boundaries, and every pulse lasts exactly one clock.
- R3: Settings with N > A give the exact ratio for every A from 0 to 15. With A = 0 all prescaler cycles are ÷16 (ratio 16×N), and with A = 15 the ratio is 16×N + 15.
- R4: A high level on ld at a rising edge stages n_in (14 bits) and a_in (4 bits). A setting staged during a period leaves that period's length unchanged and applies from the next period.
- R5: While run is low, no pulse is produced and the clock-form output stays low. When run rises, a full period of the staged setting follows before the first pulse.
- R6: After reset the output is low and the staged setting is N = 17, A = 0, giving a ratio of 272 without any load.
- R7: In clock-output form, the output toggles on every period boundary, starting from low. Its level after k boundaries is k mod 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | High: divider counts; low: standby, held at period start |
| ld | input | 1 | Load strobe for n_in and a_in |
| n_in | input | 14 | Programmable-counter setting N |
| a_in | input | 4 | Swallow-counter setting A |
| div_out | output | 1 | One-clock pulse per period, or toggle per period (parameter) |

## Verification
The pulse is due after exactly the T-th rising edge that samples run high. The bench raises run at a falling edge, counts each following rising edge, and compares the output at the next falling edge against the count modulo the period. A setting loaded mid-period is expected to keep the old length for the boundary in progress and the new length for the next interval. The bench computes each boundary by adding the old period once and the new one thereafter. The clock-form instance is compared at the same falling edges against the parity of the boundaries passed, and standby is checked on every cycle it lasts.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

   typedef enum bit {
      OUT_PULSE = 1'b0,
      OUT_CLOCK = 1'b1
   } out_mode_e;

   function automatic int unsigned sw_ratio(input int unsigned n,
                                            input int unsigned a,
                                            input int unsigned pre_w);
      return n * (32'd1 << pre_w) + a;
   endfunction

endpackage

// File: rtl/sw_stage.sv
module sw_stage #(
   parameter int N_W   = 14,
   parameter int A_W   = 4,
   parameter int N_RST = 17,
   parameter int A_RST = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld,
   input  logic [N_W-1:0] n_in,
   input  logic [A_W-1:0] a_in,
   output logic [N_W-1:0] n_q,
   output logic [A_W-1:0] a_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q <= N_W'(N_RST);
         a_q <= A_W'(A_RST);
      end else if (ld) begin
         n_q <= n_in;
         a_q <= a_in;
      end
   end

   AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (n_q == $past(n_in) && a_q == $past(a_in))); // R4

endmodule

// File: rtl/sw_prescaler.sv
module sw_prescaler #(
   parameter int PRE_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic ext,
   output logic tc
);

   localparam int              PC_W   = PRE_W + 1;
   localparam logic [PC_W-1:0] LAST_S = PC_W'((1 << PRE_W) - 1);
   localparam logic [PC_W-1:0] LAST_L = PC_W'(1 << PRE_W);

   logic [PC_W-1:0] cnt_q;
   logic [PC_W-1:0] last;

   assign last = ext ? LAST_L : LAST_S;
   assign tc   = run && (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || tc)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + PC_W'(1);
   end

   AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST_L); // R1

   AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt_q == '0); // R5

endmodule

// File: rtl/sw_chain.sv
module sw_chain #(
   parameter int N_W   = 14,
   parameter int A_W   = 4,
   parameter int N_RST = 17,
   parameter int A_RST = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic           tc,
   input  logic [N_W-1:0] n_ld,
   input  logic [A_W-1:0] a_ld,
   output logic           ext,
   output logic           boundary
);

   logic [N_W-1:0] m_q;
   logic [A_W-1:0] s_q;

   assign ext      = (s_q != '0);
   assign boundary = tc && (m_q == N_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q <= N_W'(N_RST);
         s_q <= A_W'(A_RST);
      end else if (!run || boundary) begin
         m_q <= n_ld;
         s_q <= a_ld;
      end else if (tc) begin
         m_q <= m_q - N_W'(1);
         if (ext)
            s_q <= s_q - A_W'(1);
      end
   end

   AST_SWALLOW_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ext) |-> (m_q > N_W'(s_q))); // R3

   AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |=> (m_q == $past(n_ld) && s_q == $past(a_ld))); // R4

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
   parameter int                     PRE_W    = 4,
   parameter int                     N_W      = 14,
   parameter int                     A_W      = 4,
   parameter int                     N_RST    = 17,
   parameter int                     A_RST    = 0,
   parameter pswallow_pkg::out_mode_e OUT_MODE = pswallow_pkg::OUT_PULSE
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic           ld,
   input  logic [N_W-1:0] n_in,
   input  logic [A_W-1:0] a_in,
   output logic           div_out
);

   localparam int unsigned RST_RATIO = pswallow_pkg::sw_ratio(N_RST, A_RST, PRE_W);

   if (A_W > PRE_W) begin : g_bad_aw
      $error("swallow width exceeds prescaler width");
   end
   if (N_RST <= A_RST || N_RST >= (1 << N_W)) begin : g_bad_rst
      $error("reset setting must satisfy N > A and fit N_W");
   end
   if (RST_RATIO < 2) begin : g_bad_ratio
      $error("reset ratio too small");
   end

   logic [N_W-1:0] n_st;
   logic [A_W-1:0] a_st;
   logic           ext;
   logic           tc;
   logic           boundary;
   logic           pulse_q;

   sw_stage #(.N_W(N_W), .A_W(A_W), .N_RST(N_RST), .A_RST(A_RST)) u_stage (
      .clk  (clk),
      .rst_n(rst_n),
      .ld   (ld),
      .n_in (n_in),
      .a_in (a_in),
      .n_q  (n_st),
      .a_q  (a_st)
   );

   sw_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .ext  (ext),
      .tc   (tc)
   );

   sw_chain #(.N_W(N_W), .A_W(A_W), .N_RST(N_RST), .A_RST(A_RST)) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .tc      (tc),
      .n_ld    (n_st),
      .a_ld    (a_st),
      .ext     (ext),
      .boundary(boundary)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pulse_q <= 1'b0;
      else
         pulse_q <= run && boundary;
   end

   if (OUT_MODE == pswallow_pkg::OUT_CLOCK) begin : g_clock
      logic tog_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tog_q <= 1'b0;
         else if (!run)
            tog_q <= 1'b0;
         else if (boundary)
            tog_q <= ~tog_q;
      end
      assign div_out = tog_q;

      AST_TOGGLE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
         (run && !boundary) |=> $stable(tog_q)); // R7
   end else begin : g_pulse
      assign div_out = pulse_q;
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q); // R2

   AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !pulse_q); // R5

endmodule

// File: tb/sim_pswallow_div.sv
`timescale 1ns/1ps
module sim_pswallow_div;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic        ld = 1'b0;
   logic [13:0] n_in = '0;
   logic [3:0]  a_in = '0;
   logic        pulse_o;
   logic        clk_o;

   int checks = 0;
   int failures = 0;
   int k = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pswallow_div u0 (
      .clk(clk), .rst_n(rst_n), .run(run), .ld(ld),
      .n_in(n_in), .a_in(a_in), .div_out(pulse_o)
   );

   pswallow_div #(.OUT_MODE(pswallow_pkg::OUT_CLOCK)) u1 (
      .clk(clk), .rst_n(rst_n), .run(run), .ld(ld),
      .n_in(n_in), .a_in(a_in), .div_out(clk_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, k);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      k++;
   endtask

   // Runs from standby: optional load of (n,a), optional mid-period load of
   // (n2,a2) at cycle chg_at, then checks nper boundaries.
   task automatic run_seq(input bit do_load, input int n, input int a,
                          input int chg_at, input int n2, input int a2,
                          input int nper, input string req);
      int t1;
      int t2;
      int next_b;
      int nb;
      int stray;
      t1 = 16 * n + a;
      t2 = (chg_at >= 0) ? 16 * n2 + a2 : t1;
      if (do_load) begin
         n_in = 14'(n);
         a_in = 4'(a);
         ld = 1'b1;
         cyc();
         ld = 1'b0;
         cyc();
      end
      run = 1'b1;
      k = 0;
      next_b = t1;
      nb = 0;
      stray = 0;
      while (nb < nper) begin
         cyc();
         if (k == next_b) begin
            nb++;
            chk(pulse_o == 1'b1, req, int'(pulse_o), 1);
            chk(clk_o == 1'(nb % 2), "R7", int'(clk_o), nb % 2);
            next_b += (nb == 1) ? t2 : t2;
         end else if (pulse_o) begin
            stray++;
         end
         if (k == chg_at) begin
            n_in = 14'(n2);
            a_in = 4'(a2);
            ld = 1'b1;
         end else begin
            ld = 1'b0;
         end
      end
      ld = 1'b0;
      chk(stray == 0, "R2", stray, 0);
      run = 1'b0;
      cyc();
   endtask

   initial begin
      #2000000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(pulse_o == 1'b0 && clk_o == 1'b0, "R6", int'(pulse_o), 0);
      rst_n = 1'b1;
      cyc();
      chk(pulse_o == 1'b0, "R6", int'(pulse_o), 0);

      // R6: default setting 17/0 gives 272 without any load
      run_seq(1'b0, 17, 0, -1, 0, 0, 2, "R6");

      // R1 / R3: several ratios, including A = 0 and A = 15
      run_seq(1'b1, 20, 3, -1, 0, 0, 3, "R1");
      run_seq(1'b1, 18, 0, -1, 0, 0, 3, "R3");
      run_seq(1'b1, 17, 15, -1, 0, 0, 3, "R3");
      run_seq(1'b1, 25, 9, -1, 0, 0, 2, "R1");

      // R4: load mid-period; current period 323, later ones 272
      run_seq(1'b1, 20, 3, 100, 17, 0, 3, "R4");

      // R5: stop mid-period, hold standby, restart with a new staged value
      n_in = 14'd18;
      a_in = 4'd5;
      ld = 1'b1;
      cyc();
      ld = 1'b0;
      cyc();
      run = 1'b1;
      repeat (100) cyc();
      run = 1'b0;
      begin
         int loud;
         loud = 0;
         for (int i = 0; i < 40; i++) begin
            cyc();
            if (i > 0 && (pulse_o || clk_o)) loud++;
            if (i == 10) begin
               n_in = 14'd19;
               a_in = 4'd7;
               ld = 1'b1;
            end else begin
               ld = 1'b0;
            end
         end
         chk(loud == 0, "R5", loud, 0);
      end
      run_seq(1'b0, 19, 7, -1, 0, 0, 2, "R5");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule